// File: doc/BRIEF.md
# Vector Lane to General Register Mover

This block decodes a 32-bit move instruction that copies a single element of a 128-bit vector value into a 64-bit general-purpose result. There are two variants. The signed variant sign-extends the element. The unsigned variant zero-extends it. Each variant can target a 32-bit or a 64-bit destination.

The element width and the element index are packed together into one 5-bit field. The lowest set bit of that field selects the width, and the bits above it give the index. Which widths are allowed depends on the variant and on the destination width. An encoding that matches the move but uses a forbidden combination is flagged as undefined and produces no write. An encoding that does not match the move at all is ignored, so a neighbouring decoder can claim it.

The caller presents the instruction, a valid strobe and the source vector value, all in the same cycle. One clock later the block presents a registered result, the destination register number, a write strobe and an undefined flag.

Top module: `vlane_to_gpr`

## Requirements
- R1: An instruction is claimed only when bit 31 is 0, bits 29..21 equal 9'h070, and bits 15..10 equal 6'h0B (signed variant) or 6'h0F (unsigned variant). A valid instruction that is not claimed leaves both `out_we` and `out_undef` low one cycle later, and leaves `out_data` and `out_rd` unchanged.
- R2: The size field is bits 20..16, written f[4:0]. The element width and index are chosen by the first test that matches:
  - f[0]=1: byte, index f[4:1];
  - f[1]=1: halfword, index f[4:2];
  - f[2]=1: word, index f[4:3];
  - f[3]=1: doubleword, index f[4].
  
  If f[3:0]=0, a claimed instruction is undefined.
- R3: The signed variant accepts byte and halfword elements for either destination width. It accepts a word element only when bit 30 = 1. Any other claimed signed encoding raises `out_undef` and gives no write.
- R4: The unsigned variant with bit 30 = 0 accepts byte, halfword and word elements. With bit 30 = 1 it accepts only a doubleword element. Any other claimed unsigned encoding raises `out_undef` and gives no write.
- R5: Element k of width W occupies vector bits k*W+W-1 down to k*W, so element 0 is the least significant.
- R6: The signed variant sign-extends the element to the destination width. When bit 30 = 0 (32-bit destination), `out_data[63:32]` is zero.
- R7: The unsigned variant zero-extends the element to 64 bits.
- R8: Outputs are registered and appear one clock after `in_valid`. `out_we` and `out_undef` are single-cycle pulses and are never high together. On a write, `out_rd` equals instruction bits 4..0. `out_data` and `out_rd` change only on a write.
- R9: A synchronous active-high reset clears `out_we`, `out_undef`, `out_data` and `out_rd`. A valid instruction presented during reset produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 32 | Instruction word |
| in_vec | input | 128 | Source vector value |
| out_data | output | 64 | Extended element |
| out_rd | output | 5 | Destination register number |
| out_we | output | 1 | Write strobe, one cycle |
| out_undef | output | 1 | Undefined-encoding flag, one cycle |

## Verification
The bench builds the block with its default widths: a 128-bit vector and a 64-bit result. With these widths every element size from byte to doubleword has real lanes, and the topmost lane of each size is reachable.

It walks all 32 size-field values for both variants and both destination widths, against two vector patterns. The second pattern puts 0x80 and 0x7F in lanes so that the edges of sign extension are exercised. Unclaimed encodings, an instruction presented during reset, and the idle cycle after a pulse are checked separately.

// File: rtl/vmov_pkg.sv
package vmov_pkg;
  localparam int INSN_W = 32;
  localparam logic [8:0] FIXED_MID = 9'h070;
  localparam logic [5:0] OP_SIGNED = 6'h0B;
  localparam logic [5:0] OP_UNSIGNED = 6'h0F;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_DBL  = 2'd3
  } elem_sz_e;

  typedef struct packed {
    logic     claim;
    logic     legal;
    logic     sext;
    logic     wide;
    elem_sz_e sz;
    logic [3:0] idx;
    logic [4:0] rd;
  } mov_dec_t;
endpackage

// File: rtl/vmov_decode.sv
module vmov_decode
  import vmov_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mov_dec_t          dec
);
  logic [4:0] fld;
  logic [5:0] op;
  logic       size_found;

  assign fld = insn[20:16];
  assign op  = insn[15:10];

  always_comb begin
    dec = '0;
    size_found = 1'b1;
    dec.claim = !insn[31] && (insn[29:21] == FIXED_MID) &&
                ((op == OP_SIGNED) || (op == OP_UNSIGNED));
    dec.sext = (op == OP_SIGNED);
    dec.wide = insn[30];
    dec.rd   = insn[4:0];
    // lowest set bit of the field picks the element width
    if (fld[0]) begin
      dec.sz  = ESZ_BYTE;
      dec.idx = fld[4:1];
    end else if (fld[1]) begin
      dec.sz  = ESZ_HALF;
      dec.idx = {1'b0, fld[4:2]};
    end else if (fld[2]) begin
      dec.sz  = ESZ_WORD;
      dec.idx = {2'b00, fld[4:3]};
    end else if (fld[3]) begin
      dec.sz  = ESZ_DBL;
      dec.idx = {3'b000, fld[4]};
    end else begin
      size_found = 1'b0;
    end
    if (!size_found) begin
      dec.legal = 1'b0;
    end else if (dec.sext) begin
      dec.legal = (dec.sz == ESZ_BYTE) || (dec.sz == ESZ_HALF) ||
                  ((dec.sz == ESZ_WORD) && dec.wide);
    end else if (dec.wide) begin
      dec.legal = (dec.sz == ESZ_DBL);
    end else begin
      dec.legal = (dec.sz != ESZ_DBL);
    end
  end
endmodule

// File: rtl/vmov_lane_pick.sv
module vmov_lane_pick
  import vmov_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int GPR_W = 64
) (
  input  logic [VEC_W-1:0] vec,
  input  elem_sz_e         sz,
  input  logic [3:0]       idx,
  input  logic             sext,
  input  logic             wide,
  output logic [GPR_W-1:0] val
);
  localparam int NSZ   = 4;
  localparam int HALFW = GPR_W / 2;

  logic [GPR_W-1:0] zcand [NSZ];
  logic [GPR_W-1:0] hmask [NSZ];
  logic             msb   [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = VEC_W / LW;
    localparam int IW = (NL > 1) ? $clog2(NL) : 1;
    logic [LW-1:0] lanes [NL];
    logic [LW-1:0] sel;
    always_comb begin
      for (int k = 0; k < NL; k++) begin
        lanes[k] = vec[k*LW +: LW];
      end
    end
    assign sel = lanes[idx[IW-1:0]];
    assign msb[s] = sel[LW-1];
    if (LW < GPR_W) begin : g_narrow
      assign zcand[s] = {{(GPR_W-LW){1'b0}}, sel};
      assign hmask[s] = {{(GPR_W-LW){1'b1}}, {LW{1'b0}}};
    end else begin : g_full
      assign zcand[s] = sel[GPR_W-1:0];
      assign hmask[s] = '0;
    end
  end

  logic [GPR_W-1:0] ext;
  always_comb begin
    ext = zcand[sz];
    if (sext && msb[sz]) begin
      ext = ext | hmask[sz];
    end
    if (!wide) begin
      ext[GPR_W-1:HALFW] = '0;
    end
    val = ext;
  end
endmodule

// File: rtl/vlane_to_gpr.sv
module vlane_to_gpr
  import vmov_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int GPR_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSN_W-1:0]  in_insn,
  input  logic [VEC_W-1:0]   in_vec,
  output logic [GPR_W-1:0]   out_data,
  output logic [4:0]         out_rd,
  output logic               out_we,
  output logic               out_undef
);
  localparam int HALFW = GPR_W / 2;

  mov_dec_t         dec;
  logic [GPR_W-1:0] picked;
  logic             accept;

  vmov_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  vmov_lane_pick #(.VEC_W(VEC_W), .GPR_W(GPR_W)) u_pick (
    .vec  (in_vec),
    .sz   (dec.sz),
    .idx  (dec.idx),
    .sext (dec.sext),
    .wide (dec.wide),
    .val  (picked)
  );

  assign accept = in_valid && dec.claim && dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_we    <= 1'b0;
      out_undef <= 1'b0;
      out_data  <= '0;
      out_rd    <= '0;
    end else begin
      out_we    <= accept;
      out_undef <= in_valid && dec.claim && !dec.legal;
      if (accept) begin
        out_data <= picked;
        out_rd   <= dec.rd;
      end
    end
  end

  // R8: write and undefined never coincide
  a_r8_we_undef_excl: assert property (@(posedge clk) disable iff (rst)
    !(out_we && out_undef));

  // R8: no pulse without a valid instruction one cycle earlier
  a_r8_pulse_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_we && !out_undef));

  // R8: result holds when no write occurs
  a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(out_data) && $stable(out_rd));

  // R1: unclaimed instruction is silent
  a_r1_unclaimed_silent: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_insn[31] || in_insn[29:21] != FIXED_MID)) |=>
      (!out_we && !out_undef));

  // R6: 32-bit destination leaves the upper half zero
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_insn[30]) |=> (out_data[GPR_W-1:HALFW] == '0));

  // R2: empty size field on a claimed instruction is undefined
  a_r2_empty_size_undef: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.claim && in_insn[19:16] == 4'b0000) |=> out_undef);

  // R3: signed word element into 32-bit destination is undefined
  a_r3_signed_word_narrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.claim && in_insn[15:10] == OP_SIGNED && !in_insn[30] &&
     in_insn[18:16] == 3'b100) |=> out_undef);

  // R4: unsigned 64-bit destination needs a doubleword element
  a_r4_unsigned_wide_dbl: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.claim && in_insn[15:10] == OP_UNSIGNED && in_insn[30] &&
     in_insn[19:16] != 4'b1000) |=> out_undef);
endmodule

// File: tb/sim_vlane_to_gpr.sv
module sim_vlane_to_gpr;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  in_insn;
  logic [127:0] in_vec;
  logic [63:0]  out_data;
  logic [4:0]   out_rd;
  logic         out_we;
  logic         out_undef;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vlane_to_gpr u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_vec(in_vec), .out_data(out_data), .out_rd(out_rd),
    .out_we(out_we), .out_undef(out_undef)
  );

  localparam logic [127:0] VEC_A =
    {32'hf8f7f6f5, 32'hf4f3f2f1, 32'h08070605, 32'h04030201};
  localparam logic [127:0] VEC_B =
    {32'h7f80ff00, 32'h00ff807f, 32'h80000000, 32'h7fff8000};

  typedef struct packed {
    bit          sg;
    bit          q;
    logic [4:0]  fld;
    logic [4:0]  rd;
    bit          we;
    bit          ud;
    logic [63:0] d;
  } tv_t;

  localparam int NTAB = 17;
  localparam tv_t TAB [NTAB] = '{
    '{1'b1, 1'b0, 5'h01, 5'd0,  1'b1, 1'b0, 64'h0000000000000001},
    '{1'b1, 1'b0, 5'h19, 5'd3,  1'b1, 1'b0, 64'h00000000fffffff5},
    '{1'b1, 1'b1, 5'h1B, 5'd4,  1'b1, 1'b0, 64'hfffffffffffffff6},
    '{1'b1, 1'b0, 5'h12, 5'd5,  1'b1, 1'b0, 64'h00000000fffff2f1},
    '{1'b1, 1'b1, 5'h16, 5'd6,  1'b1, 1'b0, 64'hfffffffffffff4f3},
    '{1'b1, 1'b1, 5'h1C, 5'd7,  1'b1, 1'b0, 64'hfffffffff8f7f6f5},
    '{1'b1, 1'b1, 5'h0C, 5'd8,  1'b1, 1'b0, 64'h0000000008070605},
    '{1'b1, 1'b0, 5'h04, 5'd9,  1'b0, 1'b1, 64'h0},
    '{1'b1, 1'b1, 5'h08, 5'd10, 1'b0, 1'b1, 64'h0},
    '{1'b0, 1'b0, 5'h19, 5'd11, 1'b1, 1'b0, 64'h00000000000000f5},
    '{1'b0, 1'b0, 5'h12, 5'd12, 1'b1, 1'b0, 64'h000000000000f2f1},
    '{1'b0, 1'b0, 5'h14, 5'd13, 1'b1, 1'b0, 64'h00000000f4f3f2f1},
    '{1'b0, 1'b1, 5'h18, 5'd14, 1'b1, 1'b0, 64'hf8f7f6f5f4f3f2f1},
    '{1'b0, 1'b1, 5'h01, 5'd15, 1'b0, 1'b1, 64'h0},
    '{1'b0, 1'b0, 5'h08, 5'd16, 1'b0, 1'b1, 64'h0},
    '{1'b0, 1'b0, 5'h10, 5'd17, 1'b0, 1'b1, 64'h0},
    '{1'b1, 1'b1, 5'h1F, 5'd31, 1'b1, 1'b0, 64'hfffffffffffffff8}
  };

  function automatic logic [31:0] enc(bit sg, bit q, logic [4:0] fld, logic [4:0] rd);
    return {1'b0, q, 9'h070, fld, (sg ? 6'h0B : 6'h0F), 5'd3, rd};
  endfunction

  // independent model: {we, undef, data}
  function automatic logic [65:0] model(bit sg, bit q, logic [4:0] fld, logic [127:0] v);
    int sz;
    int lw;
    int ix;
    bit ok;
    logic [63:0] msk;
    logic [63:0] e;
    if (fld[0]) sz = 0;
    else if (fld[1]) sz = 1;
    else if (fld[2]) sz = 2;
    else if (fld[3]) sz = 3;
    else sz = 4;
    if (sz == 4) ok = 0;
    else if (sg) ok = (sz <= 1) || (sz == 2 && q);
    else ok = q ? (sz == 3) : (sz <= 2);
    if (!ok) return {1'b0, 1'b1, 64'h0};
    lw = 8 << sz;
    ix = int'(fld) >> (sz + 1);
    msk = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    e = 64'(v >> (ix * lw)) & msk;
    if (sg && e[lw-1]) e = e | ~msk;
    if (!q) e[63:32] = '0;
    return {1'b1, 1'b0, e};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] insn, logic [127:0] v);
    @(negedge clk);
    in_insn  = insn;
    in_vec   = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [65:0] m;
    logic [63:0] held_d;
    logic [4:0]  held_rd;
    rst = 1'b1;
    in_valid = 1'b0;
    in_insn = '0;
    in_vec = '0;
    repeat (2) @(negedge clk);
    // R9: reset state, and valid during reset is ignored
    in_insn = enc(1'b0, 1'b0, 5'h01, 5'd7);
    in_vec = VEC_A;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 we in reset", 64'(out_we), 64'd0);
    chk("R9 undef in reset", 64'(out_undef), 64'd0);
    chk("R9 data in reset", out_data, 64'd0);
    chk("R9 rd in reset", 64'(out_rd), 64'd0);
    rst = 1'b0;

    // table of directed vectors (R3 R4 R5 R6 R7)
    for (int i = 0; i < NTAB; i++) begin
      issue(enc(TAB[i].sg, TAB[i].q, TAB[i].fld, TAB[i].rd), VEC_A);
      chk("R8 table we", 64'(out_we), 64'(TAB[i].we));
      chk("R3_R4 table undef", 64'(out_undef), 64'(TAB[i].ud));
      if (TAB[i].we) begin
        chk("R5_R6_R7 table data", out_data, TAB[i].d);
        chk("R8 table rd", 64'(out_rd), 64'(TAB[i].rd));
      end
    end

    // full walk: every field value, both variants, both widths, two vectors (R2)
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int q = 0; q < 2; q++) begin
          for (int f = 0; f < 32; f++) begin
            logic [127:0] v;
            v = (p == 0) ? VEC_A : VEC_B;
            m = model(bit'(s), bit'(q), 5'(f), v);
            issue(enc(bit'(s), bit'(q), 5'(f), 5'(f)), v);
            chk("R2 walk we", 64'(out_we), 64'(m[65]));
            chk("R2 walk undef", 64'(out_undef), 64'(m[64]));
            if (m[65]) chk("R6_R7 walk data", out_data, m[63:0]);
          end
        end
      end
    end

    // R8: pulses last one cycle
    issue(enc(1'b1, 1'b1, 5'h01, 5'd2), VEC_B);
    chk("R8 pulse high", 64'(out_we), 64'd1);
    @(negedge clk);
    chk("R8 pulse drops", 64'(out_we), 64'd0);
    issue(enc(1'b0, 1'b1, 5'h01, 5'd2), VEC_B);
    chk("R8 undef high", 64'(out_undef), 64'd1);
    @(negedge clk);
    chk("R8 undef drops", 64'(out_undef), 64'd0);

    // R1: unclaimed encodings are silent and keep the result
    issue(enc(1'b0, 1'b0, 5'h03, 5'd21), VEC_A);
    held_d = out_data;
    held_rd = out_rd;
    issue(enc(1'b0, 1'b0, 5'h05, 5'd9) | 32'h8000_0000, VEC_B);
    chk("R1 bit31 we", 64'(out_we), 64'd0);
    chk("R1 bit31 undef", 64'(out_undef), 64'd0);
    issue(enc(1'b1, 1'b0, 5'h00, 5'd9) ^ 32'h0020_0000, VEC_B);
    chk("R1 mid bits we", 64'(out_we), 64'd0);
    chk("R1 mid bits undef", 64'(out_undef), 64'd0);
    issue({1'b0, 1'b0, 9'h070, 5'h05, 6'h0A, 5'd3, 5'd9}, VEC_B);
    chk("R1 op code we", 64'(out_we), 64'd0);
    chk("R1 op code undef", 64'(out_undef), 64'd0);
    chk("R1 data held", out_data, held_d);
    chk("R1 rd held", 64'(out_rd), 64'(held_rd));

    // R9: reset mid-run clears outputs
    issue(enc(1'b1, 1'b1, 5'h11, 5'd30), VEC_B);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 data cleared", out_data, 64'd0);
    chk("R9 rd cleared", 64'(out_rd), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule